// File: doc/BRIEF.md
# Configurable UART Framing Engine

A full-duplex asynchronous serial transmitter and receiver for use beside a host that supplies characters and reads them back on plain parallel ports. A free-running baud tick is made from the input clock by an integer divisor that can be set at run time. Each serial bit lasts either 16 ticks (normal mode) or 8 ticks (high-speed mode). The character format is also set at run time: 5 to 8 data bits, no parity, even parity, odd parity or a constant (stick) parity bit, and one or two stop bits.

The transmitter accepts one character when it is idle and sends it. It reports busy for the whole frame and raises a one-cycle end-of-transmission pulse when the line goes back to idle. A break control holds the line low for as long as it is asserted. The receiver synchronises the incoming line and confirms each start edge at mid-bit. It samples each following bit at its centre and returns the character with parity, framing and break flags.

The format settings are captured when a frame starts, so changing them during a frame does not affect the frame already in progress.

Top module: `uart_frame_engine`

## Requirements
- R1: The baud tick occurs once every `div_val` clock cycles (`div_val` = 0 acts as 1). One bit lasts 16 ticks when `hs_mode`=0 and 8 ticks when `hs_mode`=1.
- R2: The idle line is high. A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then the high stop bits. The number of data bits is `data_len`+5 (00=5, 01=6, 10=7, 11=8). A character is accepted on a clock edge where `tx_valid` and `tx_ready` are both high.
- R3: With `par_en`=0 no parity bit is sent. With `par_stick`=0 and `par_even`=1, the parity bit makes the number of ones across the data bits and the parity bit even. With `par_even`=0 it makes that number odd. With `par_stick`=1 the parity bit is the inverse of `par_even`.
- R4: One stop bit is sent when `two_stop`=0 and two when `two_stop`=1. `tx_busy` is high from the accepting edge to the end of the last stop bit, and `tx_ready` is never high while `tx_busy` is high.
- R5: `tx_eot` is high for exactly one cycle, in the cycle where `tx_busy` first reads low after a frame.
- R6: While `brk_send` is high, `tx_line` is low and `tx_ready` is low, so no character is accepted.
- R7: A received character appears on `rx_data` least significant bit first, with the bits above the data length set to zero. `rx_valid` pulses for one cycle at the first stop bit.
- R8: A low pulse on `rx_line` that has ended by the middle of the start bit is rejected and produces no `rx_valid`.
- R9: `rx_par_err` is set with `rx_valid` when the received parity bit differs from the value R3 gives for the received data.
- R10: `rx_frm_err` is set with `rx_valid` when the first stop bit is sampled low.
- R11: A line held low from the start bit through the first stop bit gives one `rx_valid` with `rx_brk`=1, `rx_frm_err`=1 and `rx_data`=0. The receiver then waits for the line to go high before it looks for the next start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | DIV_W | Clock cycles per baud tick |
| hs_mode | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| data_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select / inverse stick value |
| par_stick | input | 1 | Constant parity bit |
| two_stop | input | 1 | Send two stop bits |
| brk_send | input | 1 | Hold the transmit line low |
| tx_valid | input | 1 | Character offered for transmit |
| tx_data | input | 8 | Character to transmit |
| tx_ready | output | 1 | Transmitter can accept a character |
| tx_busy | output | 1 | Frame in progress |
| tx_eot | output | 1 | One-cycle end-of-transmission pulse |
| tx_line | output | 1 | Serial output |
| rx_line | input | 1 | Serial input |
| rx_valid | output | 1 | One-cycle received-character pulse |
| rx_data | output | 8 | Received character |
| rx_par_err | output | 1 | Parity mismatch |
| rx_frm_err | output | 1 | First stop bit low |
| rx_brk | output | 1 | Break detected |

## Verification
The bench builds the block with `DIV_W`=8. It runs normal mode with a divisor of 4 (64 clocks per bit) and high-speed mode with a divisor of 3 (24 clocks per bit). Because these bit times are short, many complete frames fit in a short run, and every character length, parity mode and stop count can be covered. The half-bit margin stays wider than the tick jitter of up to one divisor at frame start, so mid-bit sampling on the line and exact frame-length windows on `tx_busy` can both be checked.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } fe_state_t;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
    logic       hs;
  } fe_cfg_t;

  function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  function automatic logic calc_par(input logic [CHAR_W-1:0] d,
                                    input logic [1:0] len,
                                    input logic even,
                                    input logic stick);
    logic x;
    x = ^(d & len_mask(len));
    if (stick) return ~even;
    return even ? x : ~x;
  endfunction

endpackage

// File: rtl/uart_fe_baudgen.sv
module uart_fe_baudgen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] lim;

  always_comb begin
    lim = (div_val == '0) ? '0 : div_val - 1'b1;
    tick = (cnt_q >= lim);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
  import uart_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  fe_cfg_t           cfg_in,
  input  logic              two_in,
  input  logic              brk_send,
  input  logic              tx_valid,
  input  logic [CHAR_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              tx_busy,
  output logic              tx_eot,
  output logic              tx_line
);

  fe_state_t         state_q, state_d;
  logic [3:0]        sub_q, sub_d;
  logic [2:0]        idx_q, idx_d;
  logic [CHAR_W-1:0] shf_q, shf_d;
  fe_cfg_t           cfg_q, cfg_d;
  logic              two_q, two_d;
  logic              par_q, par_d;
  logic              sec_q, sec_d;
  logic              eot_q, eot_d;
  logic [3:0]        last_sub;
  logic [2:0]        last_idx;
  logic              bit_end;
  logic              line_bit;

  always_comb begin
    last_sub = cfg_q.hs ? 4'd7 : 4'd15;
    last_idx = 3'd4 + {1'b0, cfg_q.len};
    bit_end  = tick && (state_q != ST_IDLE) && (sub_q == last_sub);

    state_d = state_q;
    sub_d   = sub_q;
    idx_d   = idx_q;
    shf_d   = shf_q;
    cfg_d   = cfg_q;
    two_d   = two_q;
    par_d   = par_q;
    sec_d   = sec_q;
    eot_d   = 1'b0;

    if (state_q == ST_IDLE) begin
      if (tx_valid && !brk_send) begin
        state_d = ST_START;
        sub_d   = '0;
        shf_d   = tx_data;
        cfg_d   = cfg_in;
        two_d   = two_in;
        sec_d   = 1'b0;
        par_d   = calc_par(tx_data, cfg_in.len, cfg_in.par_even, cfg_in.par_stick);
      end
    end else if (tick) begin
      sub_d = bit_end ? 4'd0 : sub_q + 4'd1;
    end

    if (bit_end) begin
      case (state_q)
        ST_START: begin
          state_d = ST_DATA;
          idx_d   = '0;
        end
        ST_DATA: begin
          shf_d = shf_q >> 1;
          if (idx_q == last_idx) state_d = cfg_q.par_en ? ST_PAR : ST_STOP;
          else                   idx_d   = idx_q + 3'd1;
        end
        ST_PAR: state_d = ST_STOP;
        ST_STOP: begin
          if (two_q && !sec_q) begin
            sec_d = 1'b1;
          end else begin
            state_d = ST_IDLE;
            eot_d   = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end

    case (state_q)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = shf_q[0];
      ST_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      shf_q   <= '0;
      cfg_q   <= '0;
      two_q   <= 1'b0;
      par_q   <= 1'b0;
      sec_q   <= 1'b0;
      eot_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sub_q   <= sub_d;
      idx_q   <= idx_d;
      shf_q   <= shf_d;
      cfg_q   <= cfg_d;
      two_q   <= two_d;
      par_q   <= par_d;
      sec_q   <= sec_d;
      eot_q   <= eot_d;
    end
  end

  assign tx_busy  = (state_q != ST_IDLE);
  assign tx_ready = (state_q == ST_IDLE) && !brk_send;
  assign tx_eot   = eot_q;
  assign tx_line  = line_bit && !brk_send;

endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
  import uart_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  fe_cfg_t           cfg_in,
  input  logic              rx_line,
  output logic              rx_valid,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_par_err,
  output logic              rx_frm_err,
  output logic              rx_brk
);

  logic              s1_q, s2_q;
  fe_state_t         state_q, state_d;
  logic [3:0]        sub_q, sub_d;
  logic [2:0]        idx_q, idx_d;
  logic [CHAR_W-1:0] dat_q, dat_d;
  fe_cfg_t           cfg_q, cfg_d;
  logic              zero_q, zero_d;
  logic              perr_q, perr_d;
  logic              vld_q, vld_d;
  logic [CHAR_W-1:0] odat_q, odat_d;
  logic              ope_q, ope_d;
  logic              ofe_q, ofe_d;
  logic              obrk_q, obrk_d;
  logic [3:0]        last_sub;
  logic [3:0]        mid_sub;
  logic [2:0]        last_idx;
  logic              bit_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rx_line;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    last_sub = cfg_q.hs ? 4'd7 : 4'd15;
    mid_sub  = cfg_q.hs ? 4'd3 : 4'd7;
    last_idx = 3'd4 + {1'b0, cfg_q.len};
    bit_end  = tick && (sub_q == last_sub);

    state_d = state_q;
    sub_d   = sub_q;
    idx_d   = idx_q;
    dat_d   = dat_q;
    cfg_d   = cfg_q;
    zero_d  = zero_q;
    perr_d  = perr_q;
    vld_d   = 1'b0;
    odat_d  = odat_q;
    ope_d   = ope_q;
    ofe_d   = ofe_q;
    obrk_d  = obrk_q;

    case (state_q)
      ST_IDLE: begin
        if (tick && !s2_q) begin
          state_d = ST_START;
          sub_d   = '0;
          cfg_d   = cfg_in;
          dat_d   = '0;
          zero_d  = 1'b1;
          perr_d  = 1'b0;
        end
      end
      ST_START: begin
        if (tick) begin
          if (sub_q == mid_sub) begin
            sub_d = '0;
            idx_d = '0;
            state_d = s2_q ? ST_IDLE : ST_DATA;
          end else begin
            sub_d = sub_q + 4'd1;
          end
        end
      end
      ST_DATA: begin
        if (tick) sub_d = bit_end ? 4'd0 : sub_q + 4'd1;
        if (bit_end) begin
          dat_d[idx_q] = s2_q;
          zero_d = zero_q && !s2_q;
          if (idx_q == last_idx) state_d = cfg_q.par_en ? ST_PAR : ST_STOP;
          else                   idx_d   = idx_q + 3'd1;
        end
      end
      ST_PAR: begin
        if (tick) sub_d = bit_end ? 4'd0 : sub_q + 4'd1;
        if (bit_end) begin
          perr_d  = s2_q != calc_par(dat_q, cfg_q.len, cfg_q.par_even, cfg_q.par_stick);
          zero_d  = zero_q && !s2_q;
          state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (tick) sub_d = bit_end ? 4'd0 : sub_q + 4'd1;
        if (bit_end) begin
          vld_d   = 1'b1;
          odat_d  = dat_q;
          ope_d   = perr_q;
          ofe_d   = !s2_q;
          obrk_d  = zero_q && !s2_q;
          state_d = s2_q ? ST_IDLE : ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (s2_q) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      dat_q   <= '0;
      cfg_q   <= '0;
      zero_q  <= 1'b0;
      perr_q  <= 1'b0;
      vld_q   <= 1'b0;
      odat_q  <= '0;
      ope_q   <= 1'b0;
      ofe_q   <= 1'b0;
      obrk_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sub_q   <= sub_d;
      idx_q   <= idx_d;
      dat_q   <= dat_d;
      cfg_q   <= cfg_d;
      zero_q  <= zero_d;
      perr_q  <= perr_d;
      vld_q   <= vld_d;
      odat_q  <= odat_d;
      ope_q   <= ope_d;
      ofe_q   <= ofe_d;
      obrk_q  <= obrk_d;
    end
  end

  assign rx_valid   = vld_q;
  assign rx_data    = odat_q;
  assign rx_par_err = ope_q;
  assign rx_frm_err = ofe_q;
  assign rx_brk     = obrk_q;

endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
  import uart_fe_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             hs_mode,
  input  logic [1:0]       data_len,
  input  logic             par_en,
  input  logic             par_even,
  input  logic             par_stick,
  input  logic             two_stop,
  input  logic             brk_send,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             tx_busy,
  output logic             tx_eot,
  output logic             tx_line,
  input  logic             rx_line,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rx_par_err,
  output logic             rx_frm_err,
  output logic             rx_brk
);

  logic    tick;
  fe_cfg_t cfg_w;

  always_comb begin
    cfg_w.len       = data_len;
    cfg_w.par_en    = par_en;
    cfg_w.par_even  = par_even;
    cfg_w.par_stick = par_stick;
    cfg_w.hs        = hs_mode;
  end

  uart_fe_baudgen #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_val (div_val),
    .tick    (tick)
  );

  uart_fe_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cfg_in   (cfg_w),
    .two_in   (two_stop),
    .brk_send (brk_send),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .tx_busy  (tx_busy),
    .tx_eot   (tx_eot),
    .tx_line  (tx_line)
  );

  uart_fe_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cfg_in     (cfg_w),
    .rx_line    (rx_line),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_par_err (rx_par_err),
    .rx_frm_err (rx_frm_err),
    .rx_brk     (rx_brk)
  );

endmodule

// File: rtl/uart_fe_chk.sv
module uart_fe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       brk_send,
  input logic       tx_line,
  input logic       tx_busy,
  input logic       tx_ready,
  input logic       tx_eot,
  input logic       rx_valid,
  input logic       rx_brk,
  input logic       rx_frm_err,
  input logic [7:0] rx_data
);

  // R6
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_send |-> !tx_line);

  // R6
  brk_noaccept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_send |-> !tx_ready);

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !brk_send) |-> tx_line);

  // R4
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !tx_busy);

  // R5
  eot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_eot |-> !tx_busy);

  // R5
  eot_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> tx_eot);

  // R5
  eot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_eot |=> !tx_eot);

  // R7
  rxv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R11
  brk_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_brk) |-> (rx_frm_err && rx_data == 8'h00));

endmodule

bind uart_frame_engine uart_fe_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .brk_send   (brk_send),
  .tx_line    (tx_line),
  .tx_busy    (tx_busy),
  .tx_ready   (tx_ready),
  .tx_eot     (tx_eot),
  .rx_valid   (rx_valid),
  .rx_brk     (rx_brk),
  .rx_frm_err (rx_frm_err),
  .rx_data    (rx_data)
);

// File: tb/uart_frame_engine_test.sv
module uart_frame_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;
  localparam int WDOG       = 150000;

  logic             clk;
  logic             rst_n;
  logic [DIV_W-1:0] div_val;
  logic             hs_mode;
  logic [1:0]       data_len;
  logic             par_en, par_even, par_stick, two_stop;
  logic             brk_send, tx_valid;
  logic [7:0]       tx_data;
  logic             tx_ready, tx_busy, tx_eot, tx_line;
  logic             rx_line;
  logic             rx_valid;
  logic [7:0]       rx_data;
  logic             rx_par_err, rx_frm_err, rx_brk;

  int checks = 0;
  int fails  = 0;
  int cap_cnt = 0;
  int eot_cnt = 0;
  int busy_cyc = 0;
  logic [7:0] cap_data;
  logic       cap_pe, cap_fe, cap_brk;
  bit         done = 0;

  uart_frame_engine #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .hs_mode(hs_mode),
    .data_len(data_len), .par_en(par_en), .par_even(par_even),
    .par_stick(par_stick), .two_stop(two_stop), .brk_send(brk_send),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .tx_busy(tx_busy), .tx_eot(tx_eot), .tx_line(tx_line),
    .rx_line(rx_line), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rx_valid) begin
      cap_cnt  <= cap_cnt + 1;
      cap_data <= rx_data;
      cap_pe   <= rx_par_err;
      cap_fe   <= rx_frm_err;
      cap_brk  <= rx_brk;
    end
    if (tx_eot)  eot_cnt  <= eot_cnt + 1;
    if (tx_busy) busy_cyc <= busy_cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic exp_par(input logic [7:0] d, input int nb,
                                   input logic ev, input logic st);
    int ones;
    if (st) return !ev;
    ones = 0;
    for (int i = 0; i < nb; i++) ones += d[i];
    return ev ? logic'(ones % 2) : logic'(1 - ones % 2);
  endfunction

  task automatic set_cfg(input logic [1:0] len, input logic pe, input logic pev,
                         input logic pst, input logic two, input logic hs,
                         input int dv);
    data_len = len; par_en = pe; par_even = pev; par_stick = pst;
    two_stop = two; hs_mode = hs; div_val = DIV_W'(dv);
  endtask

  task automatic tx_frame(input logic [7:0] d, input logic [1:0] len,
                          input logic pe, input logic pev, input logic pst,
                          input logic two, input logic hs, input int dv,
                          input string req);
    int bitc, nb, e0, b0, total, dur;
    logic [7:0] rd, msk;
    bitc = (hs ? 8 : 16) * dv;
    nb   = 5 + int'(len);
    rd   = '0;
    msk  = 8'hFF >> (8 - nb);
    @(negedge clk);
    set_cfg(len, pe, pev, pst, two, hs, dv);
    tx_data = d; tx_valid = 1'b1;
    e0 = eot_cnt; b0 = busy_cyc;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (bitc/2) @(negedge clk);
    chk(tx_line == 1'b0, "R2", {req, " start bit"}, tx_line, 0);
    for (int i = 0; i < nb; i++) begin
      repeat (bitc) @(negedge clk);
      rd[i] = tx_line;
    end
    chk((rd & msk) == (d & msk), "R2", {req, " data bits"}, rd, d & msk);
    if (pe) begin
      repeat (bitc) @(negedge clk);
      chk(tx_line == exp_par(d, nb, pev, pst), "R3", {req, " parity bit"},
          tx_line, exp_par(d, nb, pev, pst));
    end
    repeat (bitc) @(negedge clk);
    chk(tx_line && tx_busy, "R4", {req, " stop1 high and busy"},
        {tx_line, tx_busy}, 3);
    if (two) begin
      repeat (bitc) @(negedge clk);
      chk(tx_line && tx_busy, "R4", {req, " stop2 high and busy"},
          {tx_line, tx_busy}, 3);
    end
    for (int t = 0; t < 2*bitc && eot_cnt == e0; t++) @(negedge clk);
    chk(eot_cnt == e0 + 1 && !tx_busy, "R5", {req, " eot at idle"},
        eot_cnt - e0, 1);
    repeat (3) @(negedge clk);
    chk(eot_cnt == e0 + 1, "R5", {req, " eot single pulse"}, eot_cnt - e0, 1);
    total = 2 + nb + int'(pe) + int'(two);
    dur = busy_cyc - b0;
    chk(dur <= total*bitc && dur > total*bitc - dv, "R1", {req, " frame length"},
        dur, total*bitc);
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic [1:0] len,
                          input logic pe, input logic pev, input logic pst,
                          input logic hs, input int dv, input logic bad_par,
                          input logic stop_v, input string req);
    int bitc, nb, c0;
    logic p;
    logic [7:0] msk;
    bitc = (hs ? 8 : 16) * dv;
    nb   = 5 + int'(len);
    msk  = 8'hFF >> (8 - nb);
    @(negedge clk);
    set_cfg(len, pe, pev, pst, 1'b0, hs, dv);
    c0 = cap_cnt;
    rx_line = 1'b0;
    repeat (bitc) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx_line = d[i];
      repeat (bitc) @(negedge clk);
    end
    if (pe) begin
      p = exp_par(d, nb, pev, pst) ^ bad_par;
      rx_line = p;
      repeat (bitc) @(negedge clk);
    end
    rx_line = stop_v;
    repeat (bitc) @(negedge clk);
    rx_line = 1'b1;
    repeat (bitc) @(negedge clk);
    chk(cap_cnt == c0 + 1, "R7", {req, " one character"}, cap_cnt - c0, 1);
    chk(cap_data == (d & msk), "R7", {req, " data"}, cap_data, d & msk);
    chk(cap_pe == bad_par, "R9", {req, " parity flag"}, cap_pe, bad_par);
    chk(cap_fe == !stop_v, "R10", {req, " framing flag"}, cap_fe, !stop_v);
    chk(cap_brk == 1'b0, "R11", {req, " no break"}, cap_brk, 0);
  endtask

  task automatic test_reset();
    chk(tx_line == 1'b1, "R2", "reset line idle high", tx_line, 1);
    chk(!tx_busy && tx_ready, "R4", "reset busy/ready", {tx_busy, tx_ready}, 1);
    chk(!tx_eot && !rx_valid, "R5", "reset no pulses", {tx_eot, rx_valid}, 0);
  endtask

  task automatic test_tx_break();
    int e0;
    @(negedge clk);
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4);
    brk_send = 1'b1; tx_valid = 1'b1; tx_data = 8'h55;
    e0 = eot_cnt;
    @(negedge clk);
    chk(tx_line == 1'b0 && !tx_ready, "R6", "break drives low",
        {tx_line, tx_ready}, 0);
    repeat (200) @(negedge clk);
    chk(tx_line == 1'b0 && !tx_busy, "R6", "break held, nothing accepted",
        {tx_line, tx_busy}, 0);
    brk_send = 1'b0; tx_valid = 1'b0;
    @(negedge clk);
    chk(tx_line == 1'b1 && !tx_busy && tx_ready, "R6", "release to idle",
        {tx_line, tx_busy, tx_ready}, 5);
    chk(eot_cnt == e0, "R6", "no frame sent during break", eot_cnt - e0, 0);
  endtask

  task automatic test_rx_glitch();
    int c0;
    @(negedge clk);
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4);
    c0 = cap_cnt;
    rx_line = 1'b0;
    repeat (16) @(negedge clk);
    rx_line = 1'b1;
    repeat (3*64) @(negedge clk);
    chk(cap_cnt == c0, "R8", "short low pulse rejected", cap_cnt - c0, 0);
    rx_frame(8'h3C, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4, 1'b0, 1'b1, "R8 after glitch");
  endtask

  task automatic test_rx_break();
    int c0;
    @(negedge clk);
    set_cfg(2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4);
    c0 = cap_cnt;
    rx_line = 1'b0;
    repeat (20*64) @(negedge clk);
    chk(cap_cnt == c0 + 1, "R11", "long low gives one character",
        cap_cnt - c0, 1);
    chk(cap_brk && cap_fe && cap_data == 8'h00, "R11", "break flags",
        {cap_brk, cap_fe, (cap_data == 8'h00)}, 7);
    rx_line = 1'b1;
    repeat (2*64) @(negedge clk);
    chk(cap_cnt == c0 + 1, "R11", "no extra character after break",
        cap_cnt - c0, 1);
    rx_frame(8'hA7, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4, 1'b0, 1'b1, "R11 after break");
  endtask

  initial begin
    #(CLK_PERIOD * WDOG);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_line = 1'b1; brk_send = 1'b0; tx_valid = 1'b0;
    tx_data = '0;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();

    tx_frame(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4, "R1 8N1");
    tx_frame(8'h96, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3, "R1 hs 8N1");
    tx_frame(8'h35, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4, "R3 7E1");
    tx_frame(8'h35, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4, "R3 7O1");
    tx_frame(8'h0F, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4, "R3 stick one");
    tx_frame(8'h0F, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4, "R3 stick zero");
    tx_frame(8'hF3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4, "R4 5N2");
    tx_frame(8'h5A, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3, "R4 hs 8E2");
    test_tx_break();

    rx_frame(8'hC3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4, 1'b0, 1'b1, "R7 8N1");
    rx_frame(8'hFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4, 1'b0, 1'b1, "R7 5N1 masked");
    rx_frame(8'h6B, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 3, 1'b0, 1'b1, "R7 hs 8O1");
    rx_frame(8'h29, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 4, 1'b1, 1'b1, "R9 bad even");
    rx_frame(8'h11, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 4, 1'b1, 1'b1, "R9 bad stick");
    rx_frame(8'h4D, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4, 1'b0, 1'b0, "R10 stop low");
    test_rx_glitch();
    test_rx_break();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule